// File: doc/BRIEF.md
# Cascadable Preset Counter Stage

This block is a four-bit synchronous up-counter stage that can be preset. On each rising clock edge it clears, loads a parallel value, advances by one or holds. Which one it does depends on an active-low clear, an active-low load and two count-enable inputs. One parameter sets the modulus: ten (decade) or sixteen (binary). A second parameter sets whether the clear acts on the clock edge or at once.

The carry output rises when the stage sits at its terminal count and the carry-enable input is high. The other enable input plays no part in the carry. Several identical stages can therefore be chained into a wider synchronous counter. To do this, each stage's carry drives the next stage's carry-enable input, all stages share the clock, clear and load, and no gate is placed between them.

Top module: `pcount4`

## Requirements
- R1: With synchronous clear selected, a low `clr_n` sampled at a rising edge makes `count` 0 after that edge, whatever `load_n` and the enables are.
- R2: With asynchronous clear selected, `count` becomes 0 as soon as `clr_n` goes low, with no clock edge, whatever load and enables are.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `count` takes the value of `preset` after that edge, whether or not the enables are set.
- R4: Clear outranks load, load outranks counting, and counting outranks holding.
- R5: With clear and load inactive, `count` advances by one only when `en_p` and `en_t` are both 1 at the edge. Otherwise it keeps its value.
- R6: In decade mode an advance from 9 gives 0. In binary mode an advance from 15 gives 0.
- R7: `carry` is 1 exactly when `en_t` is 1 and `count` equals the terminal value (9 in decade mode, 15 in binary mode). `en_p` has no influence on it.
- R8: In decade mode, a loaded value from 10 to 15 keeps advancing by one and wraps to 0 after 15. `carry` stays 0 in those states.
- R9: Two decade stages cascade into a synchronous 0–99 counter. To chain them, the low stage's `carry` drives the high stage's `en_t` and the high stage's `en_p` is tied to 1. The high digit then advances on the same edge on which the low digit wraps from 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear (sync or async by parameter) |
| load_n | input | 1 | Active-low parallel load |
| preset | input | WIDTH | Value loaded when `load_n` is low |
| en_p | input | 1 | Count enable, counting only |
| en_t | input | 1 | Count enable that also gates the carry |
| count | output | WIDTH | Current count |
| carry | output | 1 | Terminal count and `en_t` high |

## Verification
Three pairs of functions can fall in the same cycle here. The first is load and clear: both are driven low together, and the result must be 0, not the preset. The second is the low digit's wrap and the high digit's advance: a preset of 97 is counted through 99, and the bench requires both digits to read 0 on the same edge, with the high carry seen only at 99. The third is asynchronous clear and a pending count: clear is dropped halfway through a cycle while load and both enables are active, and the output is checked for 0 before the next edge.

// File: rtl/pcount4.sv
module pcount4 #(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b1,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : '1;

  logic             adv;
  logic             at_term;
  logic [WIDTH-1:0] nxt;

  assign at_term = (count == TERM);
  assign adv     = en_p & en_t;
  assign nxt     = !load_n ? preset
                 : adv ? ((DECADE && at_term) ? '0 : count + 1'b1)
                 : count;
  assign carry   = en_t & at_term;

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n)
        if (!clr_n) count <= '0;
        else        count <= nxt;

      a_r2_async_zero: assert property (@(posedge clk) !clr_n |-> count == '0);
    end else begin : g_sync
      always_ff @(posedge clk)
        count <= !clr_n ? '0 : nxt;

      a_r1_sync_zero: assert property (@(posedge clk) !clr_n |=> count == '0);
    end
  endgenerate

  a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(preset));

  a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(count));

  a_r6_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && count == TERM) |=> count == '0);

  a_r7_carry_gate: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (en_t && count == TERM));
endmodule

// File: tb/pcount4_tb_top.sv
module pcount4_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       clr_n = 1'b0, b_clr_n = 1'b0, ld_n = 1'b1, ep = 1'b0, et = 1'b0;
  logic [3:0] p_lo = '0, p_hi = '0;
  logic [3:0] q_lo, q_hi, b_q;
  logic       co_lo, co_hi, b_co;

  pcount4 #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(ld_n), .preset(p_lo),
    .en_p(ep), .en_t(et), .count(q_lo), .carry(co_lo));

  pcount4 #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) dut_hi (
    .clk(clk), .clr_n(clr_n), .load_n(ld_n), .preset(p_hi),
    .en_p(1'b1), .en_t(co_lo), .count(q_hi), .carry(co_hi));

  pcount4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) dut_b (
    .clk(clk), .clr_n(b_clr_n), .load_n(ld_n), .preset(p_lo),
    .en_p(ep), .en_t(et), .count(b_q), .carry(b_co));

  int    n_run = 0, n_fail = 0;
  int    m_lo = 0, m_hi = 0, m_b = 0;
  string cur = "R1";
  bit    done = 0;

  function automatic int nx(int q, bit c, bit l, bit p, bit t, int pre, bit dec);
    if (!c) return 0;
    if (!l) return pre;
    if (p && t) begin
      if (dec && q == 9) return 0;
      return (q + 1) % 16;
    end
    return q;
  endfunction

  function automatic int cy(int q, bit t, bit dec);
    return (t && q == (dec ? 9 : 15)) ? 1 : 0;
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur, "lo count", int'(q_lo), m_lo);
    chk(cur, "hi count", int'(q_hi), m_hi);
    chk(cur, "bin count", int'(b_q), m_b);
    chk("R7", "lo carry", int'(co_lo), cy(m_lo, et, 1'b1));
    chk("R9", "hi carry", int'(co_hi), cy(m_hi, cy(m_lo, et, 1'b1) != 0, 1'b1));
    chk("R7", "bin carry", int'(b_co), cy(m_b, et, 1'b0));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      begin
        int tlo;
        tlo  = cy(m_lo, et, 1'b1);
        m_hi = nx(m_hi, clr_n, ld_n, 1'b1, tlo != 0, int'(p_hi), 1'b1);
        m_lo = nx(m_lo, clr_n, ld_n, ep, et, int'(p_lo), 1'b1);
        m_b  = nx(m_b, b_clr_n, ld_n, ep, et, int'(p_lo), 1'b0);
      end
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cur = "R1"; ep = 1; et = 1; ld_n = 0; p_lo = 4'd5;
    step(2);
    clr_n = 1; b_clr_n = 1; ld_n = 1;
    cur = "R5"; step(12);
    ep = 0; step(3);
    ep = 1; et = 0; step(3);
    cur = "R3"; ep = 0; et = 1; ld_n = 0; p_lo = 4'd7; p_hi = 4'd9; step(1);
    ld_n = 1; cur = "R9"; ep = 1; step(5);
    cur = "R7"; ep = 0; ld_n = 0; p_lo = 4'd9; p_hi = 4'd3; step(1);
    ld_n = 1; step(2);
    et = 0; step(1);
    cur = "R8"; et = 1; ld_n = 0; p_lo = 4'd12; p_hi = 4'd0; step(1);
    ld_n = 1; ep = 1; step(6);
    cur = "R6"; ld_n = 0; p_lo = 4'd13; step(1);
    ld_n = 1; step(4);
    cur = "R4"; clr_n = 0; ld_n = 0; p_lo = 4'd6; step(1);
    clr_n = 1; ld_n = 1; step(3);
    cur = "R2"; ld_n = 0; p_lo = 4'd11;
    #2 b_clr_n = 0;
    #1 chk("R2", "bin count immediate", int'(b_q), 0);
    m_b = 0;
    step(1);
    b_clr_n = 1; ld_n = 1; cur = "R5"; step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule